// File: doc/BRIEF.md
# CCD Readout Timing Sequencer

This block generates the digital control codes that an analog clock-driver stage turns into the vertical, horizontal, fast-dump and substrate-shutter waveforms of an interline CCD. A start strobe launches one frame. The frame opens with a frame-transfer sequence that moves photodiode charge into the vertical registers. A fixed number of lines follow, and each line is a vertical shift step followed by a burst of horizontal pixel clocks. Every duration is a parameter counted in clock cycles.

An output-mode bit selects one of two readouts. In the mode with both readout registers, the top half of the array is clocked toward its own register. In the mode with the bottom register only, the top-half phases are driven from permuted bottom patterns, and the top horizontal clocks are parked. An optional electronic-shutter pulse can be placed a programmed number of lines before the end of the frame. A per-line dump request routes a line into the fast-dump drain.

A downstream sampler uses the `busy`, `line_done` and `frame_done` strobes, plus a `pix_valid` strobe aligned with each horizontal phase-2 interval.

Top module: `ccd_readout_seq`

States and transitions:
- `ST_IDLE` goes to `ST_FR_V1` on start.
- The frame transfer runs `ST_FR_V1`, `ST_FR_3P`, `ST_FR_PD`, `ST_FR_3D`, `ST_FR_V2`, `ST_FR_TD` in that order, then `ST_LN_ARM`.
- `ST_LN_ARM` goes to `ST_LN_LEAD` if the line is dumped, otherwise to `ST_LN_VA`.
- The line runs `ST_LN_LEAD`, `ST_LN_VA`, `ST_LN_VB`, `ST_LN_VC`, `ST_LN_HS`, then `ST_PX_H1`.
- `ST_PX_H1` and `ST_PX_H2` alternate until the last pixel. After the last pixel the sequence goes to `ST_LN_TAIL` if the line is dumped, otherwise to `ST_LN_END`.
- `ST_LN_END` goes to `ST_IDLE` after the last line. It goes to `ST_SH_PULSE` at the shutter line. Otherwise it goes back to `ST_LN_ARM`.
- `ST_SH_PULSE` goes to `ST_SH_HOLD`, then to `ST_LN_ARM`.

## Requirements
- R1: `busy` rises in the cycle after a clock edge that sees `start` high in idle. A `start` pulse, or a `mode16`/`nexp` change, while `busy` is high has no effect on the running frame.
- R2: Each vertical phase k (k=1..4) is a 2-bit code at bits [2k-1:2k-2] of `v_bot`/`v_top`, with 0 = low, 1 = mid, 2 = high. The frame transfer emits, in order:
  - pattern A (8'hA0) for T_HALF_V cycles,
  - B (8'h81) for T_3P cycles,
  - P (8'h82) for T_PD cycles,
  - B for T_3D cycles,
  - C (8'h09) for T_HALF_V cycles,
  - rest (8'h28) for T_D cycles.
  Phase 1 is at code 2 only during P.
- R3: Each line emits one rest cycle, then A, B and C for T_HALF_V cycles each, then rest for T_HS cycles before its first pixel.
- R4: A line carries NH_PIX pixels. Each pixel has PIX_HALF cycles with `hb_p1` high, then PIX_HALF cycles with `hb_p2` high. `hb_rst` marks the first cycle of each pixel and `pix_valid` the first cycle of each phase-2 interval. `hb_p1` is high at all other times.
- R5: A frame has NV16 lines when `mode16`=1 and NV8 when `mode16`=0, with one `line_done` per line. `frame_done` coincides with the last `line_done`, and `busy` falls in the next cycle.
- R6: With `mode16`=1, `v_top` equals `v_bot`. With `mode16`=0, top phases 1, 2, 3, 4 carry bottom phases 1, 4, 3, 2.
- R7: With `mode16`=1, the top horizontal enables equal the bottom ones. With `mode16`=0, they are held at 0.
- R8: With `shut_en` set and 0 < `nexp` < NV:
  - `esh` is high for T_SUB cycles right after the end cycle of line NV−`nexp`;
  - the vertical code is rest throughout, and stays rest for T_HD cycles after `esh` falls;
  - `nexp` lines follow.
- R9: `nexp`=0 or `nexp`≥NV with `shut_en` set gives no `esh` pulse and the frame length of an unshuttered frame.
- R10: `dump_req` is sampled in each line's first (rest) cycle. For a dumped line:
  - `fdg` rises T_FDG cycles before the line's first vertical change and stays high through its last pixel;
  - `fdg` is then low for T_FDG cycles before the line ends;
  - `fdg` never changes in a cycle where the vertical code changes.
- R11: After reset: `busy`=0, `v_bot`=8'h28, `v_top`=8'hA0, `fdg`=0, `esh`=0, `hb_p1`=1, `hb_p2`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| start | input | 1 | frame start strobe |
| mode16 | input | 1 | 1: both readout registers, 0: bottom register only |
| shut_en | input | 1 | enable the electronic shutter pulse |
| nexp | input | LW | lines read after the shutter pulse |
| dump_req | input | 1 | route the next line to the fast-dump drain |
| v_bot | output | 8 | bottom-half vertical phase codes |
| v_top | output | 8 | top-half vertical phase codes |
| hb_p1 | output | 1 | bottom horizontal phase-1 enable |
| hb_p2 | output | 1 | bottom horizontal phase-2 enable |
| hb_rst | output | 1 | bottom reset-gate enable |
| ht_p1 | output | 1 | top horizontal phase-1 enable |
| ht_p2 | output | 1 | top horizontal phase-2 enable |
| ht_rst | output | 1 | top reset-gate enable |
| fdg | output | 1 | fast-dump gate enable |
| esh | output | 1 | substrate shutter pulse |
| busy | output | 1 | frame in progress |
| line_done | output | 1 | one-cycle end-of-line strobe |
| frame_done | output | 1 | one-cycle end-of-frame strobe |
| pix_valid | output | 1 | one-cycle strobe per pixel phase-2 interval |

## Verification
A wrong timer limit or a wrong state successor stretches or shortens the frame. That shows at once in the measured `busy` length, and it misplaces the vertical codes sampled at fixed offsets from start. A wrong line or pixel counter shows in the `line_done` and `pix_valid` counts by the end of the first frame. A wrong mode latch or phase permutation corrupts `v_top` in the first cycle after start. A misplaced shutter or dump decision appears within one line: as the wrong number of completed lines at the `esh` rising edge, or as an `fdg` edge at the wrong offset.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;

    typedef enum logic [4:0] {
        ST_IDLE, ST_FR_V1, ST_FR_3P, ST_FR_PD, ST_FR_3D, ST_FR_V2, ST_FR_TD,
        ST_LN_ARM, ST_LN_LEAD, ST_LN_VA, ST_LN_VB, ST_LN_VC, ST_LN_HS,
        ST_PX_H1, ST_PX_H2, ST_LN_TAIL, ST_LN_END, ST_SH_PULSE, ST_SH_HOLD
    } seq_state_t;

    typedef enum logic [2:0] {VP_REST, VP_A, VP_B, VP_PD, VP_C} vpat_t;

    localparam logic [1:0] LVL_LO  = 2'd0;
    localparam logic [1:0] LVL_MID = 2'd1;
    localparam logic [1:0] LVL_HI  = 2'd2;

    // rest pattern: phase1 low, phase2 high, phase3 high, phase4 low
    localparam logic [7:0] VCODE_REST = {LVL_LO, LVL_HI, LVL_HI, LVL_LO};

endpackage

// File: rtl/ccd_seq_timer.sv
module ccd_seq_timer #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic [CW-1:0] limit,
    output logic          fresh,
    output logic          expire
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt <= '0;
        else if (restart)       cnt <= '0;
        else if (cnt != '1)     cnt <= cnt + 1'b1;
    end

    assign fresh  = (cnt == '0);
    assign expire = (cnt == limit - 1'b1);

    // R1: a restarted interval always begins at zero
    a_r1_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> fresh);

endmodule

// File: rtl/ccd_seq_vmap.sv
module ccd_seq_vmap
    import ccd_seq_pkg::*;
(
    input  vpat_t      pat,
    input  logic       mode16,
    output logic [7:0] v_bot,
    output logic [7:0] v_top
);
    // index of the bottom phase that drives each top phase in single-register mode
    localparam int unsigned SRC [4] = '{0, 3, 2, 1};

    always_comb begin
        unique case (pat)
            VP_REST: v_bot = VCODE_REST;
            VP_A:    v_bot = {LVL_HI, LVL_HI, LVL_LO, LVL_LO};
            VP_B:    v_bot = {LVL_HI, LVL_LO, LVL_LO, LVL_MID};
            VP_PD:   v_bot = {LVL_HI, LVL_LO, LVL_LO, LVL_HI};
            VP_C:    v_bot = {LVL_LO, LVL_LO, LVL_HI, LVL_MID};
            default: v_bot = VCODE_REST;
        endcase
    end

    for (genvar k = 0; k < 4; k++) begin : g_top
        assign v_top[2*k+1:2*k] = mode16 ? v_bot[2*k+1:2*k]
                                         : v_bot[2*SRC[k]+1:2*SRC[k]];
    end

endmodule

// File: rtl/ccd_readout_seq.sv
module ccd_readout_seq
    import ccd_seq_pkg::*;
#(
    parameter int unsigned NH_PIX   = 1116,
    parameter int unsigned NV8      = 5392,
    parameter int unsigned NV16     = 2696,
    parameter int unsigned T_HALF_V = 320,
    parameter int unsigned T_3P     = 640,
    parameter int unsigned T_PD     = 160,
    parameter int unsigned T_3D     = 640,
    parameter int unsigned T_D      = 160,
    parameter int unsigned T_HS     = 40,
    parameter int unsigned PIX_HALF = 1,
    parameter int unsigned T_SUB    = 40,
    parameter int unsigned T_HD     = 40,
    parameter int unsigned T_FDG    = 80,
    localparam int unsigned LW      = $clog2(NV8 + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          mode16,
    input  logic          shut_en,
    input  logic [LW-1:0] nexp,
    input  logic          dump_req,
    output logic [7:0]    v_bot,
    output logic [7:0]    v_top,
    output logic          hb_p1,
    output logic          hb_p2,
    output logic          hb_rst,
    output logic          ht_p1,
    output logic          ht_p2,
    output logic          ht_rst,
    output logic          fdg,
    output logic          esh,
    output logic          busy,
    output logic          line_done,
    output logic          frame_done,
    output logic          pix_valid
);
    function automatic int unsigned longest();
        int unsigned m;
        m = T_HALF_V;
        if (T_3P > m)     m = T_3P;
        if (T_PD > m)     m = T_PD;
        if (T_3D > m)     m = T_3D;
        if (T_D > m)      m = T_D;
        if (T_HS > m)     m = T_HS;
        if (PIX_HALF > m) m = PIX_HALF;
        if (T_SUB > m)    m = T_SUB;
        if (T_HD > m)     m = T_HD;
        if (T_FDG > m)    m = T_FDG;
        return m;
    endfunction

    localparam int unsigned TMAX = longest();
    localparam int unsigned CW   = $clog2(TMAX + 1) + 1;
    localparam int unsigned PW   = $clog2(NH_PIX + 1);
    localparam logic [LW-1:0] NV8_L  = LW'(NV8);
    localparam logic [LW-1:0] NV16_L = LW'(NV16);
    localparam logic [PW-1:0] PIX_LAST = PW'(NH_PIX - 1);

    seq_state_t    state, nx;
    logic [CW-1:0] limit;
    logic          fresh, expire, adv;
    logic          mode_q, armed_q, dump_q;
    logic [LW-1:0] split_q, line_cnt, nv_q, nv_in;
    logic [PW-1:0] pix_cnt;
    logic          last_line, last_pix;
    vpat_t         vpat;

    assign nv_q      = mode_q ? NV16_L : NV8_L;
    assign nv_in     = mode16 ? NV16_L : NV8_L;
    assign last_line = (line_cnt == nv_q - 1'b1);
    assign last_pix  = (pix_cnt == PIX_LAST);
    assign adv       = (nx != state);

    ccd_seq_timer #(.CW(CW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .restart(adv), .limit(limit),
        .fresh(fresh), .expire(expire)
    );

    always_comb begin
        unique case (state)
            ST_FR_V1, ST_FR_V2,
            ST_LN_VA, ST_LN_VB, ST_LN_VC: limit = CW'(T_HALF_V);
            ST_FR_3P:                     limit = CW'(T_3P);
            ST_FR_PD:                     limit = CW'(T_PD);
            ST_FR_3D:                     limit = CW'(T_3D);
            ST_FR_TD:                     limit = CW'(T_D);
            ST_LN_HS:                     limit = CW'(T_HS);
            ST_PX_H1, ST_PX_H2:           limit = CW'(PIX_HALF);
            ST_LN_LEAD, ST_LN_TAIL:       limit = CW'(T_FDG);
            ST_SH_PULSE:                  limit = CW'(T_SUB);
            ST_SH_HOLD:                   limit = CW'(T_HD);
            default:                      limit = CW'(1);
        endcase
    end

    // next-state logic
    always_comb begin
        nx = state;
        unique case (state)
            ST_IDLE:     if (start)  nx = ST_FR_V1;
            ST_FR_V1:    if (expire) nx = ST_FR_3P;
            ST_FR_3P:    if (expire) nx = ST_FR_PD;
            ST_FR_PD:    if (expire) nx = ST_FR_3D;
            ST_FR_3D:    if (expire) nx = ST_FR_V2;
            ST_FR_V2:    if (expire) nx = ST_FR_TD;
            ST_FR_TD:    if (expire) nx = ST_LN_ARM;
            ST_LN_ARM:   nx = dump_req ? ST_LN_LEAD : ST_LN_VA;
            ST_LN_LEAD:  if (expire) nx = ST_LN_VA;
            ST_LN_VA:    if (expire) nx = ST_LN_VB;
            ST_LN_VB:    if (expire) nx = ST_LN_VC;
            ST_LN_VC:    if (expire) nx = ST_LN_HS;
            ST_LN_HS:    if (expire) nx = ST_PX_H1;
            ST_PX_H1:    if (expire) nx = ST_PX_H2;
            ST_PX_H2:    if (expire) nx = !last_pix ? ST_PX_H1 :
                                          (dump_q ? ST_LN_TAIL : ST_LN_END);
            ST_LN_TAIL:  if (expire) nx = ST_LN_END;
            ST_LN_END:   nx = last_line ? ST_IDLE :
                              ((armed_q && (line_cnt + 1'b1 == split_q)) ? ST_SH_PULSE
                                                                        : ST_LN_ARM);
            ST_SH_PULSE: if (expire) nx = ST_SH_HOLD;
            ST_SH_HOLD:  if (expire) nx = ST_LN_ARM;
            default:     nx = ST_IDLE;
        endcase
    end

    // state register and frame/line bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            mode_q   <= 1'b0;
            armed_q  <= 1'b0;
            dump_q   <= 1'b0;
            split_q  <= '0;
            line_cnt <= '0;
            pix_cnt  <= '0;
        end else begin
            state <= nx;
            if (state == ST_IDLE && start) begin
                mode_q   <= mode16;
                armed_q  <= shut_en && (nexp != '0) && (nexp < nv_in);
                split_q  <= nv_in - nexp;
                line_cnt <= '0;
            end
            if (state == ST_LN_ARM) begin
                dump_q  <= dump_req;
                pix_cnt <= '0;
            end
            if (state == ST_PX_H2 && expire) pix_cnt  <= pix_cnt + 1'b1;
            if (state == ST_LN_END)          line_cnt <= line_cnt + 1'b1;
        end
    end

    // output decode
    always_comb begin
        unique case (state)
            ST_FR_V1, ST_LN_VA:           vpat = VP_A;
            ST_FR_3P, ST_FR_3D, ST_LN_VB: vpat = VP_B;
            ST_FR_PD:                     vpat = VP_PD;
            ST_FR_V2, ST_LN_VC:           vpat = VP_C;
            default:                      vpat = VP_REST;
        endcase
        hb_p1      = (state != ST_PX_H2);
        hb_p2      = (state == ST_PX_H2);
        hb_rst     = (state == ST_PX_H1) && fresh;
        pix_valid  = (state == ST_PX_H2) && fresh;
        fdg        = dump_q && (state inside {ST_LN_LEAD, ST_LN_VA, ST_LN_VB, ST_LN_VC,
                                              ST_LN_HS, ST_PX_H1, ST_PX_H2});
        esh        = (state == ST_SH_PULSE);
        busy       = (state != ST_IDLE);
        line_done  = (state == ST_LN_END);
        frame_done = (state == ST_LN_END) && last_line;
        ht_p1      = mode_q & hb_p1;
        ht_p2      = mode_q & hb_p2;
        ht_rst     = mode_q & hb_rst;
    end

    ccd_seq_vmap u_vmap (.pat(vpat), .mode16(mode_q), .v_bot(v_bot), .v_top(v_top));

    // R10: the dump gate and the vertical codes never move in the same cycle
    a_r10_fdg_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(v_bot) |-> $stable(fdg));
    // R8: vertical clocks rest during the shutter pulse
    a_r8_esh_rest: assert property (@(posedge clk) disable iff (!rst_n)
        esh |-> (v_bot == VCODE_REST));
    // R8: vertical clocks still rest right after the pulse ends
    a_r8_hold_rest: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(esh) |-> (v_bot == VCODE_REST));
    // R1: a frame only begins after a start strobe
    a_r1_busy_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
    // R4: sampling strobe sits inside phase 2
    a_r4_valid_in_p2: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> (hb_p2 && !hb_p1));
    // R5: frame end is a line end and closes the frame
    a_r5_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> line_done ##1 !busy);

endmodule

// File: tb/sim_ccd_readout_seq.sv
module sim_ccd_readout_seq;
    localparam int PERIOD = 10;
    localparam int NH = 3, NV8 = 4, NV16 = 2;
    localparam int HV = 2, T3P = 3, TPD = 2, T3D = 3, TD = 2, THS = 2;
    localparam int PH = 1, TSUB = 2, THD = 2, TFDG = 2;

    typedef struct packed {
        logic       m;
        logic       s;
        logic [2:0] n;
        logic       d;
        logic       inj;
        logic       pulse;
    } vec_t;

    // mode, shutter, nexp, dump, inject start mid-frame, expected pulse
    localparam vec_t VECS [8] = '{
        '{1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0},
        '{1'b1, 1'b0, 3'd0, 1'b0, 1'b1, 1'b0},
        '{1'b0, 1'b1, 3'd1, 1'b0, 1'b0, 1'b1},
        '{1'b0, 1'b1, 3'd0, 1'b0, 1'b0, 1'b0},
        '{1'b0, 1'b1, 3'd4, 1'b0, 1'b0, 1'b0},
        '{1'b1, 1'b1, 3'd1, 1'b0, 1'b0, 1'b1},
        '{1'b0, 1'b0, 3'd0, 1'b1, 1'b0, 1'b0},
        '{1'b1, 1'b1, 3'd2, 1'b0, 1'b0, 1'b0}
    };

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, mode16 = 1'b0, shut_en = 1'b0, dump_req = 1'b0;
    logic [2:0] nexp = '0;
    logic [7:0] v_bot, v_top;
    logic hb_p1, hb_p2, hb_rst, ht_p1, ht_p2, ht_rst, fdg, esh, busy, line_done, frame_done, pix_valid;

    int total = 0, bad = 0;
    int r_len, r_pix, r_lines, r_fd, r_esh, r_esh_pos, r_pd, r_mapbad, r_htbad, r_fdg;

    always #(PERIOD/2) clk = ~clk;

    ccd_readout_seq #(
        .NH_PIX(NH), .NV8(NV8), .NV16(NV16), .T_HALF_V(HV), .T_3P(T3P), .T_PD(TPD),
        .T_3D(T3D), .T_D(TD), .T_HS(THS), .PIX_HALF(PH), .T_SUB(TSUB), .T_HD(THD), .T_FDG(TFDG)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .mode16(mode16), .shut_en(shut_en),
        .nexp(nexp), .dump_req(dump_req), .v_bot(v_bot), .v_top(v_top),
        .hb_p1(hb_p1), .hb_p2(hb_p2), .hb_rst(hb_rst), .ht_p1(ht_p1), .ht_p2(ht_p2),
        .ht_rst(ht_rst), .fdg(fdg), .esh(esh), .busy(busy), .line_done(line_done),
        .frame_done(frame_done), .pix_valid(pix_valid)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] perm(input logic [7:0] b);
        return {b[3:2], b[5:4], b[7:6], b[1:0]};
    endfunction

    function automatic int exp_len(input vec_t v);
        int nv, ln;
        nv = v.m ? NV16 : NV8;
        ln = 1 + 3*HV + THS + NH*2*PH + 1 + (v.d ? 2*TFDG : 0);
        return 2*HV + T3P + TPD + T3D + TD + nv*ln + (v.pulse ? TSUB + THD : 0);
    endfunction

    task automatic run_frame(input vec_t v, input bit seqc, input bit dchk);
        int idx;
        logic prev_esh;
        r_pix = 0; r_lines = 0; r_fd = 0; r_esh = 0; r_esh_pos = -1;
        r_pd = 0; r_mapbad = 0; r_htbad = 0; r_fdg = 0;
        @(negedge clk);
        mode16 = v.m; shut_en = v.s; nexp = v.n; dump_req = v.d; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        idx = 0;
        prev_esh = 1'b0;
        while (busy && idx < 3000) begin
            if (v.inj && idx == 20) begin start = 1'b1; mode16 = ~v.m; nexp = 3'd1; end
            if (v.inj && idx == 21) start = 1'b0;
            if (pix_valid) r_pix++;
            if (line_done) r_lines++;
            if (frame_done) r_fd++;
            if (esh) begin
                r_esh++;
                if (!prev_esh) r_esh_pos = r_lines;
            end
            prev_esh = esh;
            if (v_bot[1:0] == 2'd2) r_pd++;
            if (v_top != (v.m ? v_bot : perm(v_bot))) r_mapbad++;
            if ({ht_p1, ht_p2, ht_rst} != (v.m ? {hb_p1, hb_p2, hb_rst} : 3'b000)) r_htbad++;
            if (fdg) r_fdg++;
            if (seqc) begin
                case (idx)
                    0:  chk("R2 frame A", v_bot, 8'hA0);
                    2:  chk("R2 leading pedestal B", v_bot, 8'h81);
                    5:  chk("R2 transfer pulse P", v_bot, 8'h82);
                    7:  chk("R2 trailing pedestal B", v_bot, 8'h81);
                    10: chk("R2 frame C", v_bot, 8'h09);
                    12: chk("R2 delay rest", v_bot, 8'h28);
                    15: chk("R3 line A", v_bot, 8'hA0);
                    17: chk("R3 line B", v_bot, 8'h81);
                    19: chk("R3 line C", v_bot, 8'h09);
                    21: chk("R3 hs rest", v_bot, 8'h28);
                    23: chk("R4 reset+p1 first pixel", {hb_rst, hb_p1, pix_valid}, 3'b110);
                    24: chk("R4 valid+p2 first pixel", {pix_valid, hb_p2, hb_p1}, 3'b110);
                    default: ;
                endcase
            end
            if (dchk) begin
                case (idx)
                    14: chk("R10 gate low in arm", fdg, 0);
                    15: chk("R10 gate lead, rest", {fdg, v_bot}, {1'b1, 8'h28});
                    17: chk("R10 gate high at line A", {fdg, v_bot}, {1'b1, 8'hA0});
                    30: chk("R10 gate high last pixel", fdg, 1);
                    31: chk("R10 gate low in tail", fdg, 0);
                    35: chk("R10 gate lead next line", fdg, 1);
                    default: ;
                endcase
            end
            @(negedge clk);
            idx++;
        end
        if (idx >= 3000) chk("R5 frame hung", idx, 0);
        r_len = idx;
        start = 1'b0;
    endtask

    initial begin
        #(PERIOD * 100000);
        total++; bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 busy", busy, 0);
        chk("R11 v_bot rest", v_bot, 8'h28);
        chk("R11 v_top", v_top, 8'hA0);
        chk("R11 fdg/esh", {fdg, esh}, 2'b00);
        chk("R11 hclk park", {hb_p1, hb_p2}, 2'b10);

        for (int vi = 0; vi < 8; vi++) begin
            int nv, pos;
            vec_t v;
            v = VECS[vi];
            nv = v.m ? NV16 : NV8;
            pos = v.pulse ? nv - int'(v.n) : -1;
            run_frame(v, vi == 0, vi == 6);
            chk($sformatf("R1 R3 R8 R9 frame length v%0d", vi), r_len, exp_len(v));
            chk($sformatf("R4 pixel count v%0d", vi), r_pix, nv * NH);
            chk($sformatf("R5 line count v%0d", vi), r_lines, nv);
            chk($sformatf("R5 frame_done v%0d", vi), r_fd, 1);
            chk($sformatf("R8 R9 esh cycles v%0d", vi), r_esh, v.pulse ? TSUB : 0);
            chk($sformatf("R8 esh position v%0d", vi), r_esh_pos, pos);
            chk($sformatf("R2 pd cycles v%0d", vi), r_pd, TPD);
            chk($sformatf("R6 top mapping v%0d", vi), r_mapbad, 0);
            chk($sformatf("R7 top horizontal v%0d", vi), r_htbad, 0);
            chk($sformatf("R10 fdg cycles v%0d", vi), r_fdg,
                v.d ? nv * (TFDG + 3*HV + THS + 2*NH*PH) : 0);
            @(negedge clk);
            chk($sformatf("R5 idle after frame v%0d", vi), busy, 0);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule